// File: doc/BRIEF.md
# Same-Page Non-Unit Stride Detector

This block watches the stream of cache-miss line addresses and looks for a constant stride of more than one line among misses that land in the same page. It keeps a small table in which each entry tracks one page. An entry holds the last line address seen in that page, the last line-to-line distance, and a confirmation counter. When the same nonzero distance is seen often enough in a row, the block raises an allocate pulse together with the signed stride in lines. It then frees the entry so that a stream engine elsewhere can take over the pattern.

The caller presents one miss per strobe as a line address, meaning the byte address with the in-line offset already removed. Results appear on registered outputs one cycle after the strobe. The page is 4 KiB and a line is 64 bytes, so a page holds 64 lines and a stride lies between -63 and +63. Misses that find no tracked page are written into the table at a round-robin slot.

Top module: `pgstride_detect`

## Requirements
- R1: After reset all outputs are low and the table holds no page, so the first miss to any page reports no hit.
- R2: A miss whose page (line address bits above the low 6) matches no valid entry reports no hit and installs that line with distance 0 and count 0; a later miss in the same page then reports a hit.
- R3: A hit requires the same page: a miss one line away but across a 4 KiB boundary reports no hit.
- R4: On a page match the distance is the new line index minus the stored one. Equal nonzero distances increment the count, and allocate fires when the count exceeds TRAIN_THRESH (default 4). With the default this is the 7th miss of a constant-stride run. stride_o then carries that distance in lines as a two's-complement value, positive or negative.
- R5: A nonzero distance that differs from the stored one resets the count to 0, so the allocate comes TRAIN_THRESH+1 equal distances after the change.
- R6: A miss to the same line as the stored one (distance 0) reports a hit but never allocates, and a stride of zero is never output.
- R7: The entry that fires an allocate is freed, so the next miss to that page reports no hit.
- R8: Installs use a pointer that visits slots 0 to ENTRIES-1 in turn and wraps, whether or not a slot is free. With 8 entries, the 9th new page replaces the 1st.
- R9: hit_o, alloc_o and stride_o are valid in the cycle after a strobe. They are low or zero in any cycle that does not follow a strobe.
- R10: alloc_o is only ever high together with hit_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | One observed miss this cycle |
| miss_line | input | 26 | Line address of the miss (byte address >> 6) |
| hit_o | output | 1 | Previous miss matched a tracked page |
| alloc_o | output | 1 | Previous miss confirmed a stride |
| stride_o | output | 7 | Signed stride in lines, nonzero only with alloc_o |

## Verification
Constant-stride runs, one ascending by three lines and one descending by two, show that the counter fires on exactly the seventh miss and that the sign reaches the output. A run that switches stride partway must fire late and carry the new stride, which separates a resetting counter from one that merely holds. Repeated same-line misses, a neighbour across a page boundary, a revisit after an allocate, and nine distinct pages each isolate one rule of the match, free or replacement logic.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
    parameter int ADDR_W  = 32;
    parameter int LINE_LG = 6;
    parameter int PAGE_LG = 12;
    parameter int CNT_W   = 4;

    localparam int LADDR_W = ADDR_W - LINE_LG;
    localparam int SLOT_W  = PAGE_LG - LINE_LG;
    localparam int PGNUM_W = LADDR_W - SLOT_W;
    localparam int DELTA_W = SLOT_W + 1;

    typedef logic [LADDR_W-1:0]        laddr_t;
    typedef logic [PGNUM_W-1:0]        pgnum_t;
    typedef logic [SLOT_W-1:0]         slot_t;
    typedef logic signed [DELTA_W-1:0] delta_t;
    typedef logic [CNT_W-1:0]          cnt_t;

    typedef struct packed {
        logic   valid;
        laddr_t line;
        delta_t delta;
        cnt_t   cnt;
    } entry_t;
endpackage

// File: rtl/pgs_lookup.sv
module pgs_lookup
    import pgs_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  pgnum_t             page_i [ENTRIES],
    input  pgnum_t             probe_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic [ENTRIES-1:0] match;

    // Every entry compares its page in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (page_i[g] == probe_i);
    end

    // Lowest-indexed match wins.
    always_comb begin
        idx_o   = '0;
        found_o = |match;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pgs_train.sv
module pgs_train
    import pgs_pkg::*;
#(
    parameter int TRAIN_THRESH = 4
) (
    input  slot_t  cur_slot_i,
    input  delta_t cur_delta_i,
    input  cnt_t   cur_cnt_i,
    input  slot_t  new_slot_i,
    output logic   keep_o,
    output delta_t nxt_delta_o,
    output cnt_t   nxt_cnt_o,
    output logic   fire_o,
    output delta_t stride_o
);
    delta_t delta;
    cnt_t   cnt_inc;
    logic   repeat_hit;

    always_comb begin
        delta      = delta_t'({1'b0, new_slot_i}) - delta_t'({1'b0, cur_slot_i});
        cnt_inc    = cur_cnt_i + 1'b1;
        repeat_hit = (delta != '0) && (delta == cur_delta_i);

        keep_o      = 1'b1;
        nxt_delta_o = delta;
        nxt_cnt_o   = cur_cnt_i;
        fire_o      = 1'b0;
        stride_o    = '0;

        if (repeat_hit) begin
            if (int'(cnt_inc) > TRAIN_THRESH) begin
                fire_o      = 1'b1;
                stride_o    = delta;
                keep_o      = 1'b0;
                nxt_delta_o = '0;
                nxt_cnt_o   = '0;
            end else begin
                nxt_cnt_o = cnt_inc;
            end
        end else if (delta != '0) begin
            nxt_cnt_o = '0;
        end
    end
endmodule

// File: rtl/pgstride_detect.sv
module pgstride_detect
    import pgs_pkg::*;
#(
    parameter int ENTRIES      = 8,
    parameter int TRAIN_THRESH = 4,
    localparam int IDX_W       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          miss_valid,
    input  logic [pgs_pkg::LADDR_W-1:0]   miss_line,
    output logic                          hit_o,
    output logic                          alloc_o,
    output logic signed [pgs_pkg::DELTA_W-1:0] stride_o
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] tbl;
        logic   [IDX_W-1:0]   ptr;
        logic                 hit;
        logic                 alloc;
        delta_t               stride;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] valid_vec;
    pgnum_t             page_arr [ENTRIES];
    logic               found;
    logic [IDX_W-1:0]   hit_idx;
    entry_t             sel;
    logic               keep;
    delta_t             nxt_delta;
    cnt_t               nxt_cnt;
    logic               fire;
    delta_t             tr_stride;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_view
        assign valid_vec[g] = s_q.tbl[g].valid;
        assign page_arr[g]  = s_q.tbl[g].line[LADDR_W-1:SLOT_W];
    end

    pgs_lookup #(.ENTRIES(ENTRIES)) u_lookup (
        .valid_i (valid_vec),
        .page_i  (page_arr),
        .probe_i (miss_line[LADDR_W-1:SLOT_W]),
        .found_o (found),
        .idx_o   (hit_idx)
    );

    assign sel = s_q.tbl[hit_idx];

    pgs_train #(.TRAIN_THRESH(TRAIN_THRESH)) u_train (
        .cur_slot_i  (sel.line[SLOT_W-1:0]),
        .cur_delta_i (sel.delta),
        .cur_cnt_i   (sel.cnt),
        .new_slot_i  (miss_line[SLOT_W-1:0]),
        .keep_o      (keep),
        .nxt_delta_o (nxt_delta),
        .nxt_cnt_o   (nxt_cnt),
        .fire_o      (fire),
        .stride_o    (tr_stride)
    );

    always_comb begin
        s_d        = s_q;
        s_d.hit    = 1'b0;
        s_d.alloc  = 1'b0;
        s_d.stride = '0;
        if (miss_valid) begin
            if (found) begin
                s_d.hit    = 1'b1;
                s_d.alloc  = fire;
                s_d.stride = tr_stride;
                if (keep) begin
                    s_d.tbl[hit_idx] = '{valid: 1'b1, line: miss_line,
                                         delta: nxt_delta, cnt: nxt_cnt};
                end else begin
                    s_d.tbl[hit_idx] = '0;
                end
            end else begin
                s_d.tbl[s_q.ptr] = '{valid: 1'b1, line: miss_line,
                                     delta: '0, cnt: '0};
                s_d.ptr = (int'(s_q.ptr) == ENTRIES - 1) ? '0 : s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_o    = s_q.hit;
    assign alloc_o  = s_q.alloc;
    assign stride_o = s_q.stride;
endmodule

module pgs_chk
    import pgs_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   miss_valid,
    input logic   hit_o,
    input logic   alloc_o,
    input delta_t stride_o
);
    // R10
    alloc_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_o |-> hit_o);
    // R6
    no_zero_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_o |-> (stride_o != '0));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> (!hit_o && !alloc_o));
    // R9
    stride_only_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_o |-> (stride_o == '0));
    // R7
    alloc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_o |=> !alloc_o);
endmodule

bind pgstride_detect pgs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .hit_o      (hit_o),
    .alloc_o    (alloc_o),
    .stride_o   (stride_o)
);

// File: tb/pgstride_detect_bench.sv
module pgstride_detect_bench;
    import pgs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TRAIN      = 4;
    localparam int WD_CYCLES  = 50000;

    logic   clk = 1'b0;
    logic   rst_n = 1'b0;
    logic   miss_valid = 1'b0;
    laddr_t miss_line = '0;
    logic   hit_o, alloc_o;
    logic signed [DELTA_W-1:0] stride_o;

    int checks = 0;
    int errors = 0;
    int r_hit, r_alloc, r_stride;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgstride_detect #(.ENTRIES(8), .TRAIN_THRESH(TRAIN)) u_pgstride_detect (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .hit_o(hit_o), .alloc_o(alloc_o), .stride_o(stride_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        miss_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic miss(input int pg, input int ln);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_line  = LADDR_W'((pg << SLOT_W) | ln);
        @(negedge clk);
        miss_valid = 1'b0;
        r_hit    = int'(hit_o);
        r_alloc  = int'(alloc_o);
        r_stride = int'(stride_o);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 hit after reset", int'(hit_o), 0);
        chk("R1 alloc after reset", int'(alloc_o), 0);
        chk("R1 stride after reset", int'(stride_o), 0);
        miss(3, 5);
        chk("R1 first miss no hit", r_hit, 0);
    endtask

    task automatic t_install();
        do_reset();
        miss(7, 10);
        chk("R2 new page no hit", r_hit, 0);
        miss(7, 20);
        chk("R2 same page hit", r_hit, 1);
        chk("R2 no alloc", r_alloc, 0);
        @(negedge clk);
        chk("R9 idle hit low", int'(hit_o), 0);
    endtask

    task automatic t_boundary();
        do_reset();
        miss(5, 63);
        miss(6, 0);
        chk("R3 across page no hit", r_hit, 0);
        miss(5, 62);
        chk("R3 same page hit", r_hit, 1);
    endtask

    task automatic run_stride(input int pg, input int start, input int s, input string tag);
        for (int i = 0; i <= TRAIN + 2; i++) begin
            miss(pg, start + i * s);
            chk({tag, " hit"}, r_hit, (i > 0) ? 1 : 0);
            chk({tag, " alloc"}, r_alloc, (i == TRAIN + 2) ? 1 : 0);
            chk({tag, " stride"}, r_stride, (i == TRAIN + 2) ? s : 0);
        end
    endtask

    task automatic t_train();
        do_reset();
        run_stride(9, 0, 3, "R4 stride +3");
        miss(9, 30);
        chk("R7 freed entry no hit", r_hit, 0);
        do_reset();
        run_stride(11, 40, -2, "R4 stride -2");
    endtask

    task automatic t_change();
        do_reset();
        // stride 2 for four misses, then stride 5
        miss(12, 0); miss(12, 2); miss(12, 4); miss(12, 6);
        for (int i = 1; i <= TRAIN + 2; i++) begin
            miss(12, 6 + 5 * i);
            chk("R5 delayed alloc", r_alloc, (i == TRAIN + 2) ? 1 : 0);
            chk("R5 new stride", r_stride, (i == TRAIN + 2) ? 5 : 0);
        end
    endtask

    task automatic t_same_line();
        do_reset();
        for (int i = 0; i < 10; i++) begin
            miss(13, 17);
            chk("R6 same line hit", r_hit, (i > 0) ? 1 : 0);
            chk("R6 same line no alloc", r_alloc, 0);
            chk("R6 stride zero", r_stride, 0);
        end
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int p = 0; p < 9; p++) begin
            miss(20 + p, 1);
            chk("R8 fill no hit", r_hit, 0);
        end
        miss(21, 2);
        chk("R8 second page kept", r_hit, 1);
        miss(20, 2);
        chk("R8 first page replaced", r_hit, 0);
        miss(21, 3);
        chk("R8 next slot replaced", r_hit, 0);
    endtask

    initial begin
        t_reset();
        t_install();
        t_boundary();
        t_train();
        t_change();
        t_same_line();
        t_round_robin();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule